// File: doc/BRIEF.md
# Board Interrupt Source Aggregator

This block gathers the interrupt conditions of a mixed-signal I/O board into one request line. There are five sources: two analog input converters, two analog output converters and a group of digital I/O lines. Each converter signals its interrupt with a one-cycle event pulse. The block holds that pulse in a pending latch until software reads the converter's own acknowledge offset. The digital I/O group has its own controller, which supplies a pending level. This block passes that level through and never clears it.

Software finds out which sources are asking for service from an identification byte. That byte shares offset 0xF with the normal status of output converter 2. A small two-state view machine decides which of the two a read of 0xF returns. State `VIEW_STATUS` is entered at reset. The transition `SELECT_ON` (a write to 0xF with bit 5 set) moves the machine to `VIEW_ID`. The transition `SELECT_OFF` (a write to 0xF with bit 5 clear, such as the old value ANDed with 0xDF) returns it to `VIEW_STATUS`. Writes keep the current state in every other case.

A typical service routine sets the select bit and reads 0xF. For each bit set, it reads the matching acknowledge offset. It then clears the select bit so that 0xF shows output converter 2 status again.

Top module: `irq_aggregator`

## Requirements
- R1: After reset all four converter latches are clear, the view state is `VIEW_STATUS` and `irq_req` is low.
- R2: An event pulse on `cvt_evt[k]` sets a latch. While `VIEW_ID` is active, that latch shows in the ID byte at these positions: k=0 (input 1) at bit 0, k=1 (input 2) at bit 1, k=2 (output 1) at bit 2, k=3 (output 2) at bit 4.
- R3: A read of offset 0x1, 0x5, 0x9 or 0xD clears only the latch of input 1, input 2, output 1 or output 2 respectively. The latch is clear from the next cycle.
- R4: If an event pulse and the clearing read of the same latch fall in the same cycle, the latch ends up set.
- R5: Bit 3 of the ID byte follows `dio_pending` in the same cycle. No read in this block changes it.
- R6: In `VIEW_ID`, a read of 0xF returns the ID byte, and bits 7:5 of that byte are always zero.
- R7: In `VIEW_STATUS`, a read of 0xF returns `out2_status` unchanged.
- R8: A write to 0xF sets the view state from `wr_data` bit 5: 1 selects `VIEW_ID`, 0 selects `VIEW_STATUS`. Writes to any other offset leave the state unchanged.
- R9: `irq_req` is high exactly when at least one of the five ID bits is set.
- R10: Reads of any offset other than 0xF return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Register read strobe, one cycle per access |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register offset |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, valid in the cycle of `rd_en` |
| cvt_evt | input | 4 | Converter event pulses: in1, in2, out1, out2 |
| dio_pending | input | 1 | Pending level from the digital I/O controller |
| out2_status | input | 8 | Output converter 2 status byte |
| irq_req | output | 1 | Combined interrupt request |

## Verification
The first pattern raises each converter source on its own. This separates the bit-position mapping and shows that each acknowledge offset is tied to the right latch. A second pattern holds two latches and then acknowledges one of them, which shows that clearing is selective. A third pattern makes an event and its clearing read meet in the same cycle, which checks the set-wins priority. Further patterns hold the digital I/O level high while every acknowledge offset is read, toggle the select bit with all-ones and masked writes, and write the select bit to a wrong offset. Together these separate the ID view from the status view and show that the state changes only on a write to 0xF.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    localparam int ADDR_W   = 4;
    localparam int DATA_W   = 8;
    localparam int NUM_CVT  = 4;
    localparam int ID_W     = 5;
    localparam int SEL_BIT  = 5;
    localparam int DIO_BIT  = 3;
    localparam int ACK_BASE = 1;
    localparam int ACK_STEP = 4;
    localparam logic [ADDR_W-1:0] CTRL_OFS = 4'hF;

    typedef enum logic {
        VIEW_STATUS = 1'b0,
        VIEW_ID     = 1'b1
    } view_e;

    // converter index -> ID byte bit position (bit 3 belongs to digital I/O)
    function automatic int id_pos(input int k);
        return (k >= DIO_BIT) ? k + 1 : k;
    endfunction

    function automatic logic [ADDR_W-1:0] ack_ofs(input int k);
        return ADDR_W'(ACK_BASE + k * ACK_STEP);
    endfunction

endpackage

// File: rtl/irq_src_latch.sv
module irq_src_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_pulse,
    input  logic clr_read,
    output logic pend
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= 1'b0;
        end else if (set_pulse) begin
            pend <= 1'b1;
        end else if (clr_read) begin
            pend <= 1'b0;
        end
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set_pulse |=> pend);                                  // R4
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_read && !set_pulse) |=> !pend);                  // R3
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_read && !set_pulse) |=> $stable(pend));         // R3

endmodule

// File: rtl/irq_view_fsm.sv
module irq_view_fsm
    import irq_agg_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  ctrl_wr,
    input  logic  sel_req,
    output logic  show_id
);

    view_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= VIEW_STATUS;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            VIEW_STATUS: if (ctrl_wr && sel_req)  state_d = VIEW_ID;      // SELECT_ON
            VIEW_ID:     if (ctrl_wr && !sel_req) state_d = VIEW_STATUS;  // SELECT_OFF
            default:     state_d = VIEW_STATUS;
        endcase
    end

    always_comb begin
        show_id = (state_q == VIEW_ID);
    end

    AST_SEL_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && sel_req) |=> show_id);                    // R8
    AST_SEL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !sel_req) |=> !show_id);                  // R8
    AST_SEL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_wr |=> $stable(show_id));                       // R8

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import irq_agg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic [NUM_CVT-1:0] cvt_evt,
    input  logic              dio_pending,
    input  logic [DATA_W-1:0] out2_status,
    output logic              irq_req
);

    logic [NUM_CVT-1:0] pend;
    logic [NUM_CVT-1:0] ack_hit;
    logic [ID_W-1:0]    id_bits;
    logic               show_id;
    logic               ctrl_wr;

    assign ctrl_wr = wr_en && (addr == CTRL_OFS);

    irq_view_fsm u_view (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctrl_wr (ctrl_wr),
        .sel_req (wr_data[SEL_BIT]),
        .show_id (show_id)
    );

    for (genvar k = 0; k < NUM_CVT; k++) begin : g_src
        assign ack_hit[k] = rd_en && (addr == ack_ofs(k));

        irq_src_latch u_latch (
            .clk       (clk),
            .rst_n     (rst_n),
            .set_pulse (cvt_evt[k]),
            .clr_read  (ack_hit[k]),
            .pend      (pend[k])
        );

        assign id_bits[id_pos(k)] = pend[k];
    end

    assign id_bits[DIO_BIT] = dio_pending;
    assign irq_req = |id_bits;

    always_comb begin
        rd_data = '0;
        if (rd_en && addr == CTRL_OFS) begin
            if (show_id) begin
                rd_data = {{(DATA_W-ID_W){1'b0}}, id_bits};
            end else begin
                rd_data = out2_status;
            end
        end
    end

    AST_ID_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == CTRL_OFS && show_id) |-> rd_data[7:5] == 3'b000);   // R6
    AST_DIO_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        dio_pending |-> irq_req);                                             // R9
    AST_LATCH_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        (|pend) |-> irq_req);                                                 // R9
    AST_QUIET_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (pend == '0 && !dio_pending) |-> !irq_req);                           // R9
    AST_OTHER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (addr != CTRL_OFS) |-> rd_data == '0);                                // R10

endmodule

// File: tb/irq_aggregator_test.sv
module irq_aggregator_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rd_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] addr = 4'h0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic [3:0] cvt_evt = 4'h0;
    logic       dio_pending = 1'b0;
    logic [7:0] out2_status = 8'hA5;
    logic       irq_req;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    irq_aggregator uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_en       (rd_en),
        .wr_en       (wr_en),
        .addr        (addr),
        .wr_data     (wr_data),
        .rd_data     (rd_data),
        .cvt_evt     (cvt_evt),
        .dio_pending (dio_pending),
        .out2_status (out2_status),
        .irq_req     (irq_req)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one access cycle; data sampled mid-cycle before the edge that applies it
    task automatic bus_read(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1 d = rd_data;
        @(negedge clk);
        rd_en = 1'b0; addr = 4'h0;
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [7:0] v);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0; addr = 4'h0; wr_data = 8'h00;
    endtask

    task automatic pulse(input logic [3:0] m);
        @(negedge clk);
        cvt_evt = m;
        @(negedge clk);
        cvt_evt = 4'h0;
    endtask

    function automatic logic [3:0] ack_addr(input int k);
        return 4'(1 + 4 * k);
    endfunction

    function automatic logic [7:0] id_mask(input int k);
        return (k == 3) ? 8'h10 : 8'(1 << k);
    endfunction

    task automatic t_reset();
        logic [7:0] d;
        @(negedge clk);
        check("R1 irq after reset", {7'b0, irq_req}, 8'h00);
        bus_read(4'hF, d);
        check("R1 status view after reset", d, 8'hA5);
        out2_status = 8'h3C;
        bus_read(4'hF, d);
        check("R7 status passthrough", d, 8'h3C);
    endtask

    task automatic t_select_empty();
        logic [7:0] d;
        bus_write(4'hF, 8'h20);
        bus_read(4'hF, d);
        check("R8 select on gives empty ID", d, 8'h00);
    endtask

    task automatic t_each_source();
        logic [7:0] d;
        for (int k = 0; k < 4; k++) begin
            pulse(4'(1 << k));
            bus_read(4'hF, d);
            check("R2 ID bit position", d, id_mask(k));
            check("R9 irq with one latch", {7'b0, irq_req}, 8'h01);
            bus_read(ack_addr(k), d);
            check("R10 ack offset reads zero", d, 8'h00);
            bus_read(4'hF, d);
            check("R3 ack clears latch", d, 8'h00);
            check("R9 irq drops", {7'b0, irq_req}, 8'h00);
        end
    endtask

    task automatic t_selective_clear();
        logic [7:0] d;
        pulse(4'b1001);
        bus_read(4'h1, d);
        bus_read(4'hF, d);
        check("R3 only own latch cleared", d, 8'h10);
        bus_read(4'hD, d);
        bus_read(4'hF, d);
        check("R3 second ack clears", d, 8'h00);
    endtask

    task automatic t_set_wins();
        logic [7:0] d;
        pulse(4'b0100);
        @(negedge clk);
        rd_en = 1'b1; addr = 4'h9; cvt_evt = 4'b0100;
        @(negedge clk);
        rd_en = 1'b0; addr = 4'h0; cvt_evt = 4'h0;
        bus_read(4'hF, d);
        check("R4 set beats clear", d, 8'h04);
        bus_read(4'h9, d);
        bus_read(4'hF, d);
        check("R3 later ack clears", d, 8'h00);
    endtask

    task automatic t_dio_level();
        logic [7:0] d;
        @(negedge clk);
        dio_pending = 1'b1;
        #1 check("R9 irq from dio", {7'b0, irq_req}, 8'h01);
        bus_read(4'hF, d);
        check("R5 dio bit set", d, 8'h08);
        for (int k = 0; k < 4; k++) bus_read(ack_addr(k), d);
        bus_read(4'hF, d);
        check("R5 dio not cleared by reads", d, 8'h08);
        @(negedge clk);
        dio_pending = 1'b0;
        bus_read(4'hF, d);
        check("R5 dio bit follows level", d, 8'h00);
    endtask

    task automatic t_high_bits();
        logic [7:0] d;
        bus_write(4'hF, 8'hFF);
        pulse(4'hF);
        @(negedge clk);
        dio_pending = 1'b1;
        bus_read(4'hF, d);
        check("R6 all sources, top bits zero", d, 8'h1F);
        @(negedge clk);
        dio_pending = 1'b0;
        for (int k = 0; k < 4; k++) bus_read(ack_addr(k), d);
    endtask

    task automatic t_deselect();
        logic [7:0] d;
        out2_status = 8'hE7;
        bus_write(4'hF, 8'hFF & 8'hDF);
        bus_read(4'hF, d);
        check("R7 deselect restores status", d, 8'hE7);
        bus_write(4'h3, 8'h20);
        bus_read(4'hF, d);
        check("R8 write elsewhere ignored", d, 8'hE7);
        pulse(4'b0001);
        bus_read(4'h2, d);
        check("R10 other offset reads zero", d, 8'h00);
        bus_read(4'h1, d);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_select_empty();
        t_each_source();
        t_selective_clear();
        t_set_wins();
        t_dio_level();
        t_high_bits();
        t_deselect();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule